// File: doc/BRIEF.md
# Dual-Oscillator Sub-Band Calibration Controller

This controller picks the coarse sub-band code for a PLL that is built around two band-switched oscillators, a low-band one and a high-band one, with overlapping tuning ranges. When it is started, it raises a loop-open flag. External circuitry uses that flag to break the loop and force the tuning voltage to mid-supply. The controller then runs a successive-approximation search over the 5-bit code of each oscillator in turn, low band first. For every trial it asks an external frequency counter for a measurement and compares the returned count with a target. The target comes from the programmed division ratio: the integer part scaled by 16, plus the top four fractional bits.

For each oscillator it keeps the trial with the smallest absolute error. At the end it applies the result according to the mode captured at start:
- **Quadrature mode:** both oscillators run together, each on its own best code.
- **Wideband mode:** only the oscillator with the smaller residual error is enabled. On a tie the low band wins, because it draws less power.

A one-cycle done pulse ends the run. The final settings then hold until the next start.

Top module: `afc_dual_cal_ctrl`

## Requirements
- R1: After reset, loop_open, done, cnt_start, lb_en, hb_en and band_sel are 0, and both code outputs are 0.
- R2: A start pulse while idle raises loop_open on the next clock edge. On that edge quad_mode and the target are captured. The target is div_int*16 + div_frac[11:8]; the eight lower fractional bits have no effect.
- R3: Each measurement is requested by a cnt_start pulse one cycle long, raised only while loop_open is high. The next request waits for cnt_valid. A calibration issues exactly 10 requests.
- R4: The first 5 trials use the low band: band_sel=0, lb_en=1, hb_en=0, with the trial code on lb_code. The last 5 trials use the high band: band_sel=1, hb_en=1, lb_en=0, with the trial code on hb_code.
- R5: A larger code means a higher frequency. Each band's search begins at code 10000b and decides one bit per trial, MSB first. If the count exceeds the target (negative error), the bit just tried is cleared; otherwise it is kept. The next lower bit is then set for the following trial.
- R6: The best code of a band is the trial with the smallest |target - count| among its 5 trials. If two trials have equal error, the earlier one is kept.
- R7: In quadrature mode (quad_mode=1 at start) the final state is lb_en=1, hb_en=1 and band_sel=0. lb_code and hb_code carry the best low-band and best high-band codes.
- R8: In wideband mode exactly one enable is set, for the band with the smaller best error. A tie selects the low band. band_sel is 1 only when the high band is selected, and both code outputs carry the two best codes.
- R9: done is high for exactly one cycle, in the same cycle that loop_open falls. After that, all code, enable and band outputs stay constant until the next start.
- R10: A start pulse during a calibration is ignored. So are changes to quad_mode, div_int or div_frac after the start: the running calibration and its result are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a calibration (idle only) |
| quad_mode | input | 1 | 1 = quadrature mode, 0 = wideband mode |
| div_int | input | 8 | Integer part of the division ratio |
| div_frac | input | 12 | Fractional part of the division ratio |
| cnt_value | input | 12 | Frequency count returned by the counter |
| cnt_valid | input | 1 | cnt_value is valid this cycle |
| cnt_start | output | 1 | Request one frequency count |
| loop_open | output | 1 | Loop open and tuning voltage forced to mid-supply |
| lb_code | output | 5 | Low-band oscillator sub-band code |
| hb_code | output | 5 | High-band oscillator sub-band code |
| band_sel | output | 1 | 0 = low band drives the output, 1 = high band |
| lb_en | output | 1 | Low-band oscillator enable |
| hb_en | output | 1 | High-band oscillator enable |
| done | output | 1 | One-cycle end-of-calibration pulse |

## Verification
The assertions check several properties on every cycle:
- the request pulse is a single cycle and is raised only with the loop open;
- exactly one oscillator is enabled during the search;
- each decided bit moves the code in the direction given by the error sign;
- the stored minimum error never grows within a band;
- done closes the loop, with the enable pattern that the captured mode calls for, and the outputs hold while idle.

Only the bench scenarios can show the exact trial sequence, the choice of best code per band, the low-band preference on exact ties, and that a second start or a ratio change in mid-run leaves the result untouched. For these the bench models both oscillators as linear count curves and sweeps targets across their whole range and overlap.

// File: rtl/afc_cal_pkg.sv
package afc_cal_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_DECIDE
  } cal_state_e;

  localparam int  NUM_OSC   = 2;
  localparam logic BAND_LOW  = 1'b0;
  localparam logic BAND_HIGH = 1'b1;
endpackage

// File: rtl/afc_err_unit.sv
module afc_err_unit #(
  parameter int CNT_W = 12
) (
  input  logic [CNT_W-1:0] target,
  input  logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] abs_err,
  output logic             too_fast
);
  logic [CNT_W:0] diff;

  always_comb begin
    diff     = {1'b0, target} - {1'b0, count};
    too_fast = diff[CNT_W];
    if (too_fast) begin
      abs_err = CNT_W'(-diff);
    end else begin
      abs_err = diff[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/afc_sar_core.sv
module afc_sar_core #(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic              too_fast,
  output logic [CODE_W-1:0] code,
  output logic              last
);
  localparam int IDX_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;
  localparam logic [CODE_W-1:0] SEED = CODE_W'(1) << (CODE_W - 1);

  logic [IDX_W-1:0]  idx_q;
  logic [CODE_W-1:0] code_nxt;

  always_comb begin
    code_nxt = code;
    if (too_fast) begin
      code_nxt[idx_q] = 1'b0;
    end
    if (idx_q != '0) begin
      code_nxt[idx_q - IDX_W'(1)] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code  <= '0;
      idx_q <= '0;
    end else if (load) begin
      code  <= SEED;
      idx_q <= IDX_W'(CODE_W - 1);
    end else if (step) begin
      code <= code_nxt;
      if (idx_q != '0) begin
        idx_q <= idx_q - IDX_W'(1);
      end
    end
  end

  assign last = (idx_q == '0);

  assert_code_up_R5: assert property (@(posedge clk) disable iff (rst)
    (step && !load && !too_fast) |=> (code >= $past(code)));
  assert_code_down_R5: assert property (@(posedge clk) disable iff (rst)
    (step && !load && too_fast) |=> (code < $past(code)));
endmodule

// File: rtl/afc_best_reg.sv
module afc_best_reg #(
  parameter int CODE_W = 5,
  parameter int ERR_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              upd,
  input  logic [ERR_W-1:0]  abs_err,
  input  logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] best_code,
  output logic [ERR_W-1:0]  best_err
);
  logic first_q;
  logic take;

  assign take = upd && (first_q || (abs_err < best_err));

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q   <= 1'b1;
      best_code <= '0;
      best_err  <= '1;
    end else if (clr) begin
      first_q   <= 1'b1;
      best_code <= '0;
      best_err  <= '1;
    end else if (upd) begin
      first_q <= 1'b0;
      if (take) begin
        best_code <= code;
        best_err  <= abs_err;
      end
    end
  end

  assert_min_never_grows_R6: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (best_err <= $past(best_err)));
endmodule

// File: rtl/afc_dual_cal_ctrl.sv
module afc_dual_cal_ctrl
  import afc_cal_pkg::*;
#(
  parameter int CODE_W    = 5,
  parameter int INT_W     = 8,
  parameter int FRAC_W    = 12,
  parameter int FRAC_KEEP = 4,
  parameter int CNT_W     = INT_W + FRAC_KEEP
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              quad_mode,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  input  logic [CNT_W-1:0]  cnt_value,
  input  logic              cnt_valid,
  output logic              cnt_start,
  output logic              loop_open,
  output logic [CODE_W-1:0] lb_code,
  output logic [CODE_W-1:0] hb_code,
  output logic              band_sel,
  output logic              lb_en,
  output logic              hb_en,
  output logic              done
);
  cal_state_e        state_q;
  logic              band_q;
  logic              mode_q;
  logic [CNT_W-1:0]  target_q;
  logic [CNT_W-1:0]  target_nxt;
  logic              cnt_start_q;
  logic              loop_open_q;
  logic              done_q;
  logic [CODE_W-1:0] fin_lb_q;
  logic [CODE_W-1:0] fin_hb_q;
  logic              fin_lb_en_q;
  logic              fin_hb_en_q;
  logic              fin_band_q;

  logic [CNT_W-1:0]  abs_err;
  logic              too_fast;
  logic [CODE_W-1:0] sar_code;
  logic              sar_last;
  logic              sar_load;
  logic              sar_step;
  logic              meas_ok;
  logic              best_clr;

  logic [CODE_W-1:0] best_code [NUM_OSC];
  logic [CNT_W-1:0]  best_err  [NUM_OSC];

  logic unused_frac_bits;
  assign unused_frac_bits = ^div_frac[FRAC_W-FRAC_KEEP-1:0];
  assign target_nxt = {div_int, div_frac[FRAC_W-1 -: FRAC_KEEP]};

  assign meas_ok  = (state_q == ST_WAIT) && cnt_valid;
  assign sar_step = meas_ok;
  assign sar_load = ((state_q == ST_IDLE) && start) ||
                    (meas_ok && sar_last && (band_q == BAND_LOW));
  assign best_clr = (state_q == ST_IDLE) && start;

  afc_err_unit #(.CNT_W(CNT_W)) u_err (
    .target   (target_q),
    .count    (cnt_value),
    .abs_err  (abs_err),
    .too_fast (too_fast)
  );

  afc_sar_core #(.CODE_W(CODE_W)) u_sar (
    .clk      (clk),
    .rst      (rst),
    .load     (sar_load),
    .step     (sar_step),
    .too_fast (too_fast),
    .code     (sar_code),
    .last     (sar_last)
  );

  for (genvar b = 0; b < NUM_OSC; b++) begin : g_best
    afc_best_reg #(.CODE_W(CODE_W), .ERR_W(CNT_W)) u_best (
      .clk       (clk),
      .rst       (rst),
      .clr       (best_clr),
      .upd       (meas_ok && (band_q == 1'(b))),
      .abs_err   (abs_err),
      .code      (sar_code),
      .best_code (best_code[b]),
      .best_err  (best_err[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      band_q      <= BAND_LOW;
      mode_q      <= 1'b0;
      target_q    <= '0;
      cnt_start_q <= 1'b0;
      loop_open_q <= 1'b0;
      done_q      <= 1'b0;
      fin_lb_q    <= '0;
      fin_hb_q    <= '0;
      fin_lb_en_q <= 1'b0;
      fin_hb_en_q <= 1'b0;
      fin_band_q  <= 1'b0;
    end else begin
      done_q      <= 1'b0;
      cnt_start_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            mode_q      <= quad_mode;
            target_q    <= target_nxt;
            band_q      <= BAND_LOW;
            loop_open_q <= 1'b1;
            state_q     <= ST_REQ;
          end
        end
        ST_REQ: begin
          cnt_start_q <= 1'b1;
          state_q     <= ST_WAIT;
        end
        ST_WAIT: begin
          if (cnt_valid) begin
            if (!sar_last) begin
              state_q <= ST_REQ;
            end else if (band_q == BAND_LOW) begin
              band_q  <= BAND_HIGH;
              state_q <= ST_REQ;
            end else begin
              state_q <= ST_DECIDE;
            end
          end
        end
        ST_DECIDE: begin
          fin_lb_q <= best_code[0];
          fin_hb_q <= best_code[1];
          if (mode_q) begin
            fin_lb_en_q <= 1'b1;
            fin_hb_en_q <= 1'b1;
            fin_band_q  <= BAND_LOW;
          end else if (best_err[0] <= best_err[1]) begin
            fin_lb_en_q <= 1'b1;
            fin_hb_en_q <= 1'b0;
            fin_band_q  <= BAND_LOW;
          end else begin
            fin_lb_en_q <= 1'b0;
            fin_hb_en_q <= 1'b1;
            fin_band_q  <= BAND_HIGH;
          end
          loop_open_q <= 1'b0;
          done_q      <= 1'b1;
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cnt_start = cnt_start_q;
  assign loop_open = loop_open_q;
  assign done      = done_q;
  assign band_sel  = loop_open_q ? band_q : fin_band_q;
  assign lb_en     = loop_open_q ? (band_q == BAND_LOW)  : fin_lb_en_q;
  assign hb_en     = loop_open_q ? (band_q == BAND_HIGH) : fin_hb_en_q;
  assign lb_code   = loop_open_q ? ((band_q == BAND_LOW)  ? sar_code : '0) : fin_lb_q;
  assign hb_code   = loop_open_q ? ((band_q == BAND_HIGH) ? sar_code : '0) : fin_hb_q;

  assert_req_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_start |=> !cnt_start);
  assert_req_in_cal_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_start |-> loop_open);
  assert_one_osc_cal_R4: assert property (@(posedge clk) disable iff (rst)
    loop_open |-> ($countones({lb_en, hb_en}) == 1));
  assert_quad_both_R7: assert property (@(posedge clk) disable iff (rst)
    (done && mode_q) |-> (lb_en && hb_en && !band_sel));
  assert_wide_single_R8: assert property (@(posedge clk) disable iff (rst)
    (done && !mode_q) |-> ($countones({lb_en, hb_en}) == 1) && (band_sel == hb_en));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_closes_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (!loop_open && $past(loop_open)));
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (!loop_open && !start) |=> $stable({lb_code, hb_code, lb_en, hb_en, band_sel}));
endmodule

// File: tb/afc_dual_cal_ctrl_bench.sv
`timescale 1ns/1ps
module afc_dual_cal_ctrl_bench;
  localparam int LB_BASE = 1000;
  localparam int HB_BASE = 1800;
  localparam int STEP    = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        quad_mode = 1'b0;
  logic [7:0]  div_int = '0;
  logic [11:0] div_frac = '0;
  logic [11:0] cnt_value = '0;
  logic        cnt_valid = 1'b0;
  logic        cnt_start, loop_open, band_sel, lb_en, hb_en, done;
  logic [4:0]  lb_code, hb_code;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  int n_trials;
  int got_band [16];
  int got_code [16];
  int exp_band [10];
  int exp_code [10];
  int best_c [2];
  int best_e [2];

  always #2.5 clk = ~clk;

  afc_dual_cal_ctrl u_afc_dual_cal_ctrl (
    .clk(clk), .rst(rst), .start(start), .quad_mode(quad_mode),
    .div_int(div_int), .div_frac(div_frac), .cnt_value(cnt_value),
    .cnt_valid(cnt_valid), .cnt_start(cnt_start), .loop_open(loop_open),
    .lb_code(lb_code), .hb_code(hb_code), .band_sel(band_sel),
    .lb_en(lb_en), .hb_en(hb_en), .done(done)
  );

  function automatic int osc_count(input int band, input int code);
    return (band != 0) ? HB_BASE + code * STEP : LB_BASE + code * STEP;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  // frequency counter model: answers each request from the code on the ports
  initial begin
    forever begin
      @(negedge clk);
      if (cnt_start === 1'b1) begin
        automatic int b = int'(band_sel);
        automatic int c = band_sel ? int'(hb_code) : int'(lb_code);
        if (n_trials < 16) begin
          got_band[n_trials] = b;
          got_code[n_trials] = c;
        end
        n_trials++;
        repeat (2) @(negedge clk);
        cnt_value = 12'(osc_count(b, c));
        cnt_valid = 1'b1;
        @(negedge clk);
        cnt_valid = 1'b0;
      end
    end
  end

  // reference search per R5/R6
  task automatic model(input int t);
    for (int b = 0; b < 2; b++) begin
      int code = 16;
      bit first = 1;
      for (int k = 4; k >= 0; k--) begin
        int idx = b * 5 + (4 - k);
        int err = t - osc_count(b, code);
        int a = (err < 0) ? -err : err;
        exp_band[idx] = b;
        exp_code[idx] = code;
        if (first || a < best_e[b]) begin
          best_e[b] = a;
          best_c[b] = code;
          first = 0;
        end
        if (err < 0) code = code & ~(1 << k);
        if (k > 0) code = code | (1 << (k - 1));
      end
    end
  endtask

  task automatic run_cal(input int t, input bit qm, input bit inject);
    int cycles = 0;
    int seq_bad = -1;
    int lbc, hbc, le, he, bs;
    model(t);
    quad_mode = qm;
    div_int   = 8'(t >> 4);
    div_frac  = 12'(((t & 15) << 8) | 8'hA5);   // low bits must be ignored (R2)
    n_trials  = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(loop_open === 1'b1, "R2 loop_open after start", int'(loop_open), 1);
    while (done !== 1'b1 && cycles < 3000) begin
      if (inject && cycles == 15) begin
        start = 1'b1; quad_mode = ~qm; div_int = ~div_int; div_frac = ~div_frac;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cycles++;
    end
    start = 1'b0;
    chk(done === 1'b1, "R9 done reached", int'(done), 1);
    chk(loop_open === 1'b0, "R9 loop_open low with done", int'(loop_open), 0);
    chk(n_trials == 10, "R3 request count", n_trials, 10);
    for (int i = 0; i < 10; i++) begin
      if (seq_bad < 0 && (got_band[i] != exp_band[i] || got_code[i] != exp_code[i]))
        seq_bad = i;
    end
    if (seq_bad >= 0)
      chk(0, "R4/R5 trial sequence", got_band[seq_bad] * 100 + got_code[seq_bad],
          exp_band[seq_bad] * 100 + exp_code[seq_bad]);
    else
      chk(1, "R4 R5 trial sequence", 0, 0);
    chk(int'(lb_code) == best_c[0], "R6 low best code", int'(lb_code), best_c[0]);
    chk(int'(hb_code) == best_c[1], "R6 high best code", int'(hb_code), best_c[1]);
    if (qm) begin
      chk({lb_en, hb_en, band_sel} == 3'b110, "R7 quad enables",
          int'({lb_en, hb_en, band_sel}), 6);
    end else begin
      int pick_hi = (best_e[1] < best_e[0]) ? 1 : 0;   // tie -> low band (R8)
      int exp_v = pick_hi ? 3'b011 : 3'b100;
      chk(int'({lb_en, hb_en, band_sel}) == exp_v, "R8 wideband choice",
          int'({lb_en, hb_en, band_sel}), exp_v);
    end
    lbc = int'(lb_code); hbc = int'(hb_code); le = int'(lb_en); he = int'(hb_en); bs = int'(band_sel);
    repeat (6) @(negedge clk);
    chk(done === 1'b0, "R9 done single cycle", int'(done), 0);
    chk(int'(lb_code) == lbc && int'(hb_code) == hbc && int'(lb_en) == le &&
        int'(hb_en) == he && int'(band_sel) == bs, "R9 outputs hold",
        int'({lb_code, hb_code}), lbc * 32 + hbc);
  endtask

  initial begin
    #(200000 * 5);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk({loop_open, done, cnt_start, lb_en, hb_en, band_sel} == 6'b0, "R1 reset controls",
        int'({loop_open, done, cnt_start, lb_en, hb_en, band_sel}), 0);
    chk(lb_code == 5'd0 && hb_code == 5'd0, "R1 reset codes", int'({lb_code, hb_code}), 0);
    // exact tie at zero error in both bands: low band wins (R8)
    run_cal(2000, 1'b0, 1'b0);
    chk(lb_en === 1'b1 && hb_en === 1'b0, "R8 tie to low band", int'(lb_en), 1);
    run_cal(2000, 1'b1, 1'b0);
    // start and input changes during a run are ignored (R10)
    run_cal(1530, 1'b0, 1'b1);
    run_cal(2710, 1'b1, 1'b1);
    run_cal(2300, 1'b0, 1'b1);
    // range extremes
    run_cal(0, 1'b0, 1'b0);
    run_cal(4095, 1'b0, 1'b0);
    run_cal(4095, 1'b1, 1'b0);
    // sweep across both bands and the overlap, both modes
    for (int t = 900; t <= 3200; t += 23) begin
      run_cal(t, 1'b0, 1'b0);
      run_cal(t, 1'b1, 1'b0);
    end
    finish_run();
  end
endmodule